// File: doc/BRIEF.md
# Exception Entry and Mode-Change Controller

This block owns the current status word of a 32-bit core that keeps separate register banks per operating mode. On each clock it decides whether an exception is taken. When one is, it moves the core into the privileged mode that serves that exception and writes the old status word into that mode's saved copy. It also hands the return address to the register file for that mode's link register, masks interrupts according to the exception type, leaves the compact instruction state, and redirects fetch to the exception's vector.

Outside exceptions it carries out two other status updates. The first is an explicit status write, whose control byte is honoured only while the core is privileged. The second is a return that restores the current mode's saved copy and reloads the program counter. All results are registered, so they appear one cycle after the inputs that cause them. Requests are level signals. The register file, fetch and memory sit outside the block and act on the write strobes it produces.

Top module: `exc_entry_ctrl`

## Requirements
- R1: While `rst` is high at a clock edge, the next cycle shows `status` = 0x000000D3 and `pc_we`=1 with `pc_out`=0. That status means mode 0x13, interrupt mask bit 7 set, fast-interrupt mask bit 6 set and compact-state bit 5 clear. `spsr_we` and `lr_we` are 0, and every saved copy is cleared to zero.
- R2: When an exception is taken, the next cycle shows `spsr_we`=1, `spsr_mode` equal to the target mode, and `spsr_wdata` equal to the status word held before the entry. That value is also stored in the block's own saved copy for that mode.
- R3: The mode field is `status[4:0]`, and 0x10 is the unprivileged user mode. Undefined instruction enters 0x1B, supervisor call enters 0x13, both aborts enter 0x17, IRQ enters 0x12 and FIQ enters 0x11. Saved copies exist for exactly these five modes.
- R4: On entry, `pc_we`=1 and `pc_out` is the vector. The vectors are 0x00 for reset, 0x04 for undefined instruction, 0x08 for supervisor call, 0x0C for prefetch abort, 0x10 for data abort, 0x18 for IRQ and 0x1C for FIQ.
- R5: On entry, `lr_we`=1, `lr_mode` is the target mode and `lr_wdata` is `next_pc`.
- R6: Every entry sets bit 7. Bit 6 is set on FIQ entry (and by reset); every other entry leaves it unchanged.
- R7: Every entry clears bit 5 (compact instruction state).
- R8: Among simultaneous eligible requests, exactly one is taken, in this order: data abort, FIQ, IRQ, prefetch abort, undefined instruction, supervisor call.
- R9: IRQ is not taken while bit 7 is set, and FIQ is not taken while bit 6 is set. A request held high is taken in the first cycle its mask reads clear.
- R10: An explicit write always updates bits 31:28 from `sr_wr_data`. It updates bits 7:0 only when the mode is not 0x10; from user mode those bits stay as they were.
- R11: A return loads `pc_out`=`rte_addr` with `pc_we`=1. If the current mode has a saved copy, `status` becomes that copy; otherwise `status` is unchanged. A return takes precedence over an explicit write in the same cycle.
- R12: An exception taken in the same cycle as an explicit write or a return wins. The write or return is discarded, and the entry uses the status word as it was before that cycle.
- R13: `pc_we`, `spsr_we` and `lr_we` are single-cycle pulses that are low in any cycle after which no event occurred.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; also the reset exception |
| req_und | input | 1 | Undefined-instruction request |
| req_svc | input | 1 | Supervisor-call request |
| req_pabt | input | 1 | Prefetch-abort request |
| req_dabt | input | 1 | Data-abort request |
| irq_req | input | 1 | Interrupt request (level) |
| fiq_req | input | 1 | Fast interrupt request (level) |
| next_pc | input | 32 | Address of the instruction after the current one |
| sr_wr_en | input | 1 | Explicit status-word write |
| sr_wr_data | input | 32 | Data for the explicit write |
| rte_en | input | 1 | Return with status restore |
| rte_addr | input | 32 | Return address taken from the current link register |
| status | output | 32 | Current status word |
| spsr_we | output | 1 | Saved-copy write strobe |
| spsr_mode | output | 5 | Mode whose saved copy is written |
| spsr_wdata | output | 32 | Saved-copy data |
| lr_we | output | 1 | Link-register write strobe |
| lr_mode | output | 5 | Mode whose link register is written |
| lr_wdata | output | 32 | Link-register data |
| pc_we | output | 1 | Program-counter load strobe |
| pc_out | output | 32 | New program counter |

## Verification
The interesting collision is an exception request arriving in the same cycle as an explicit status write or a return. All three want to rewrite the status word. The bench places a prefetch abort beside a write that would change the masks, and an undefined instruction beside a return. It then expects the entry to be built from the old status word, with the write and the return leaving no trace. A long random phase produces many more such collisions, and every output is compared each cycle against a behavioural model.

// File: rtl/exc_pkg.sv
package exc_pkg;
  typedef enum logic [2:0] {
    EX_NONE, EX_UND, EX_SVC, EX_PABT, EX_DABT, EX_IRQ, EX_FIQ
  } exc_e;

  localparam int MODE_W = 5;
  localparam logic [MODE_W-1:0] M_USR = 5'h10;
  localparam logic [MODE_W-1:0] M_FIQ = 5'h11;
  localparam logic [MODE_W-1:0] M_IRQ = 5'h12;
  localparam logic [MODE_W-1:0] M_SVC = 5'h13;
  localparam logic [MODE_W-1:0] M_ABT = 5'h17;
  localparam logic [MODE_W-1:0] M_UND = 5'h1B;

  localparam int BIT_T = 5;
  localparam int BIT_F = 6;
  localparam int BIT_I = 7;
  localparam int CTRL_W = 8;
  localparam int FLAG_W = 4;
  localparam int NUM_BANKS = 5;

  function automatic logic [MODE_W-1:0] bank_mode(input int idx);
    case (idx)
      0: bank_mode = M_FIQ;
      1: bank_mode = M_IRQ;
      2: bank_mode = M_SVC;
      3: bank_mode = M_ABT;
      default: bank_mode = M_UND;
    endcase
  endfunction
endpackage

// File: rtl/exc_arbiter.sv
module exc_arbiter
  import exc_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic req_und,
  input  logic req_svc,
  input  logic req_pabt,
  input  logic req_dabt,
  input  logic irq_req,
  input  logic fiq_req,
  input  logic mask_i,
  input  logic mask_f,
  output exc_e sel,
  output logic take
);
  localparam int NREQ = 6;

  logic [NREQ-1:0] elig;
  logic [NREQ-1:0] grant;

  // index 0 is the highest priority
  assign elig[0] = req_dabt;
  assign elig[1] = fiq_req & ~mask_f;
  assign elig[2] = irq_req & ~mask_i;
  assign elig[3] = req_pabt;
  assign elig[4] = req_und;
  assign elig[5] = req_svc;

  always_comb begin
    grant = '0;
    for (int i = NREQ - 1; i >= 0; i--) begin
      if (elig[i]) grant = NREQ'(1) << i;
    end
  end

  always_comb begin
    unique case (1'b1)
      grant[0]: sel = EX_DABT;
      grant[1]: sel = EX_FIQ;
      grant[2]: sel = EX_IRQ;
      grant[3]: sel = EX_PABT;
      grant[4]: sel = EX_UND;
      grant[5]: sel = EX_SVC;
      default:  sel = EX_NONE;
    endcase
  end

  assign take = |grant;

  AST_SINGLE_GRANT: assert property (@(posedge clk) disable iff (rst)
    $onehot0(grant)); // R8

  AST_IRQ_HELD_OFF: assert property (@(posedge clk) disable iff (rst)
    (irq_req && mask_i) |-> (sel != EX_IRQ)); // R9

  AST_FIQ_HELD_OFF: assert property (@(posedge clk) disable iff (rst)
    (fiq_req && mask_f) |-> (sel != EX_FIQ)); // R9
endmodule

// File: rtl/exc_vector.sv
module exc_vector
  import exc_pkg::*;
#(
  parameter int DW = 32,
  parameter logic [DW-1:0] VEC_BASE = '0
) (
  input  exc_e              sel,
  input  logic [DW-1:0]     cur_status,
  output logic [DW-1:0]     ent_status,
  output logic [MODE_W-1:0] tgt_mode,
  output logic [DW-1:0]     vector
);
  localparam int OFF_W = 8;
  logic [OFF_W-1:0] off;

  always_comb begin
    tgt_mode = M_SVC;
    off      = 8'h00;
    unique case (sel)
      EX_UND:  begin tgt_mode = M_UND; off = 8'h04; end
      EX_SVC:  begin tgt_mode = M_SVC; off = 8'h08; end
      EX_PABT: begin tgt_mode = M_ABT; off = 8'h0C; end
      EX_DABT: begin tgt_mode = M_ABT; off = 8'h10; end
      EX_IRQ:  begin tgt_mode = M_IRQ; off = 8'h18; end
      EX_FIQ:  begin tgt_mode = M_FIQ; off = 8'h1C; end
      default: begin tgt_mode = M_SVC; off = 8'h00; end
    endcase
  end

  always_comb begin
    ent_status               = cur_status;
    ent_status[MODE_W-1:0]   = tgt_mode;
    ent_status[BIT_T]        = 1'b0;
    ent_status[BIT_I]        = 1'b1;
    if (sel == EX_FIQ) ent_status[BIT_F] = 1'b1;
  end

  assign vector = VEC_BASE + DW'(off);
endmodule

// File: rtl/spsr_bank.sv
module spsr_bank
  import exc_pkg::*;
#(
  parameter int DW = 32,
  parameter int NB = NUM_BANKS
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [MODE_W-1:0] wmode,
  input  logic [DW-1:0]     wdata,
  input  logic [MODE_W-1:0] rmode,
  output logic [DW-1:0]     rdata,
  output logic              rhit
);
  logic [DW-1:0] bank_q [NB];
  logic [NB-1:0] wsel;
  logic [NB-1:0] rsel;

  for (genvar g = 0; g < NB; g++) begin : g_dec
    assign wsel[g] = we && (wmode == bank_mode(g));
    assign rsel[g] = (rmode == bank_mode(g));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NB; i++) bank_q[i] <= '0;
    end else begin
      for (int i = 0; i < NB; i++) begin
        if (wsel[i]) bank_q[i] <= wdata;
      end
    end
  end

  always_comb begin
    rdata = '0;
    rhit  = 1'b0;
    for (int i = 0; i < NB; i++) begin
      if (rsel[i]) begin
        rdata = bank_q[i];
        rhit  = 1'b1;
      end
    end
  end

  AST_ONE_BANK_WRITTEN: assert property (@(posedge clk) disable iff (rst)
    $onehot0(wsel)); // R2
endmodule

// File: rtl/exc_entry_ctrl.sv
module exc_entry_ctrl
  import exc_pkg::*;
#(
  parameter int DW = 32,
  parameter logic [DW-1:0] VEC_BASE = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_und,
  input  logic              req_svc,
  input  logic              req_pabt,
  input  logic              req_dabt,
  input  logic              irq_req,
  input  logic              fiq_req,
  input  logic [DW-1:0]     next_pc,
  input  logic              sr_wr_en,
  input  logic [DW-1:0]     sr_wr_data,
  input  logic              rte_en,
  input  logic [DW-1:0]     rte_addr,
  output logic [DW-1:0]     status,
  output logic              spsr_we,
  output logic [MODE_W-1:0] spsr_mode,
  output logic [DW-1:0]     spsr_wdata,
  output logic              lr_we,
  output logic [MODE_W-1:0] lr_mode,
  output logic [DW-1:0]     lr_wdata,
  output logic              pc_we,
  output logic [DW-1:0]     pc_out
);
  localparam int FLAG_LO = DW - FLAG_W;
  localparam logic [DW-1:0] RESET_STATUS =
    DW'({1'b1, 1'b1, 1'b0, M_SVC});

  logic [DW-1:0]     status_q;
  exc_e              sel;
  logic              take;
  logic [DW-1:0]     ent_status;
  logic [MODE_W-1:0] tgt_mode;
  logic [DW-1:0]     vector;
  logic [DW-1:0]     bank_rd;
  logic              bank_hit;
  logic              privileged;
  logic [DW-1:0]     wr_status;

  exc_arbiter u_arb (
    .clk      (clk),
    .rst      (rst),
    .req_und  (req_und),
    .req_svc  (req_svc),
    .req_pabt (req_pabt),
    .req_dabt (req_dabt),
    .irq_req  (irq_req),
    .fiq_req  (fiq_req),
    .mask_i   (status_q[BIT_I]),
    .mask_f   (status_q[BIT_F]),
    .sel      (sel),
    .take     (take)
  );

  exc_vector #(.DW(DW), .VEC_BASE(VEC_BASE)) u_vec (
    .sel        (sel),
    .cur_status (status_q),
    .ent_status (ent_status),
    .tgt_mode   (tgt_mode),
    .vector     (vector)
  );

  spsr_bank #(.DW(DW), .NB(NUM_BANKS)) u_bank (
    .clk   (clk),
    .rst   (rst),
    .we    (take),
    .wmode (tgt_mode),
    .wdata (status_q),
    .rmode (status_q[MODE_W-1:0]),
    .rdata (bank_rd),
    .rhit  (bank_hit)
  );

  assign privileged = (status_q[MODE_W-1:0] != M_USR);

  always_comb begin
    wr_status = status_q;
    wr_status[DW-1:FLAG_LO] = sr_wr_data[DW-1:FLAG_LO];
    if (privileged) wr_status[CTRL_W-1:0] = sr_wr_data[CTRL_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      status_q   <= RESET_STATUS;
      pc_we      <= 1'b1;
      pc_out     <= VEC_BASE;
      spsr_we    <= 1'b0;
      lr_we      <= 1'b0;
      spsr_mode  <= '0;
      spsr_wdata <= '0;
      lr_mode    <= '0;
      lr_wdata   <= '0;
    end else begin
      pc_we   <= 1'b0;
      spsr_we <= 1'b0;
      lr_we   <= 1'b0;
      if (take) begin
        status_q   <= ent_status;
        spsr_we    <= 1'b1;
        spsr_mode  <= tgt_mode;
        spsr_wdata <= status_q;
        lr_we      <= 1'b1;
        lr_mode    <= tgt_mode;
        lr_wdata   <= next_pc;
        pc_we      <= 1'b1;
        pc_out     <= vector;
      end else if (rte_en) begin
        if (bank_hit) status_q <= bank_rd;
        pc_we  <= 1'b1;
        pc_out <= rte_addr;
      end else if (sr_wr_en) begin
        status_q <= wr_status;
      end
    end
  end

  assign status = status_q;

  AST_ENTRY_SAVES_OLD: assert property (@(posedge clk) disable iff (rst)
    take |=> (spsr_we && spsr_wdata == $past(status_q))); // R2

  AST_ENTRY_MASKS_IRQ: assert property (@(posedge clk) disable iff (rst)
    take |=> status_q[BIT_I]); // R6

  AST_ENTRY_STD_STATE: assert property (@(posedge clk) disable iff (rst)
    take |=> !status_q[BIT_T]); // R7

  AST_ENTRY_PRIVILEGED: assert property (@(posedge clk) disable iff (rst)
    take |=> (status_q[MODE_W-1:0] != M_USR)); // R3

  AST_USER_CTRL_LOCKED: assert property (@(posedge clk) disable iff (rst)
    (sr_wr_en && !rte_en && !take && !privileged)
      |=> (status_q[CTRL_W-1:0] == $past(status_q[CTRL_W-1:0]))); // R10

  AST_IDLE_NO_STROBE: assert property (@(posedge clk) disable iff (rst)
    (!take && !rte_en) |=> (!pc_we && !spsr_we && !lr_we)); // R13
endmodule

// File: tb/tb_exc_entry_ctrl.sv
module tb_exc_entry_ctrl;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic        rst = 1'b1;
  logic        req_und = 0, req_svc = 0, req_pabt = 0, req_dabt = 0;
  logic        irq_req = 0, fiq_req = 0;
  logic [31:0] next_pc = '0;
  logic        sr_wr_en = 0;
  logic [31:0] sr_wr_data = '0;
  logic        rte_en = 0;
  logic [31:0] rte_addr = '0;
  logic [31:0] status, spsr_wdata, lr_wdata, pc_out;
  logic        spsr_we, lr_we, pc_we;
  logic [4:0]  spsr_mode, lr_mode;

  exc_entry_ctrl dut (
    .clk(clk), .rst(rst), .req_und(req_und), .req_svc(req_svc),
    .req_pabt(req_pabt), .req_dabt(req_dabt), .irq_req(irq_req),
    .fiq_req(fiq_req), .next_pc(next_pc), .sr_wr_en(sr_wr_en),
    .sr_wr_data(sr_wr_data), .rte_en(rte_en), .rte_addr(rte_addr),
    .status(status), .spsr_we(spsr_we), .spsr_mode(spsr_mode),
    .spsr_wdata(spsr_wdata), .lr_we(lr_we), .lr_mode(lr_mode),
    .lr_wdata(lr_wdata), .pc_we(pc_we), .pc_out(pc_out)
  );

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 0;

  // behavioural reference state
  logic [31:0] m_st;
  logic [31:0] m_saved [int];
  logic        m_pcwe, m_spwe, m_lrwe;
  logic [31:0] m_pc, m_spd, m_lrd;
  logic [4:0]  m_spm, m_lrm;

  function automatic bit has_copy(input logic [4:0] m);
    return m == 5'h11 || m == 5'h12 || m == 5'h13 || m == 5'h17 || m == 5'h1B;
  endfunction

  task automatic model_step();
    int kind;
    logic [4:0] tm;
    logic [31:0] vec;
    if (rst) begin
      m_st = 32'h0000_00D3;
      m_pcwe = 1; m_pc = 0; m_spwe = 0; m_lrwe = 0;
      m_saved.delete();
      return;
    end
    m_pcwe = 0; m_spwe = 0; m_lrwe = 0;
    kind = 0;
    if (req_dabt) kind = 4;
    else if (fiq_req && !m_st[6]) kind = 6;
    else if (irq_req && !m_st[7]) kind = 5;
    else if (req_pabt) kind = 3;
    else if (req_und) kind = 1;
    else if (req_svc) kind = 2;
    case (kind)
      1: begin tm = 5'h1B; vec = 32'h04; end
      2: begin tm = 5'h13; vec = 32'h08; end
      3: begin tm = 5'h17; vec = 32'h0C; end
      4: begin tm = 5'h17; vec = 32'h10; end
      5: begin tm = 5'h12; vec = 32'h18; end
      6: begin tm = 5'h11; vec = 32'h1C; end
      default: begin tm = 5'h13; vec = 32'h00; end
    endcase
    if (kind != 0) begin
      m_spwe = 1; m_spm = tm; m_spd = m_st; m_saved[int'(tm)] = m_st;
      m_lrwe = 1; m_lrm = tm; m_lrd = next_pc;
      m_pcwe = 1; m_pc = vec;
      m_st[4:0] = tm; m_st[5] = 0; m_st[7] = 1;
      if (kind == 6) m_st[6] = 1;
    end else if (rte_en) begin
      if (has_copy(m_st[4:0]))
        m_st = m_saved.exists(int'(m_st[4:0])) ? m_saved[int'(m_st[4:0])] : 32'h0;
      m_pcwe = 1; m_pc = rte_addr;
    end else if (sr_wr_en) begin
      m_st[31:28] = sr_wr_data[31:28];
      if (m_st[4:0] != 5'h10) m_st[7:0] = sr_wr_data[7:0];
    end
  endtask

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %08h expected %08h", req, what, act, exp);
    end
  endtask

  task automatic cyc(input string req);
    model_step();
    @(posedge clk);
    #5;
    chk(req, "status", status, m_st);
    chk(req, "pc_we", 32'(pc_we), 32'(m_pcwe));
    chk(req, "spsr_we", 32'(spsr_we), 32'(m_spwe));
    chk(req, "lr_we", 32'(lr_we), 32'(m_lrwe));
    if (m_pcwe) chk(req, "pc_out", pc_out, m_pc);
    if (m_spwe) begin
      chk(req, "spsr_mode", 32'(spsr_mode), 32'(m_spm));
      chk(req, "spsr_wdata", spsr_wdata, m_spd);
    end
    if (m_lrwe) begin
      chk(req, "lr_mode", 32'(lr_mode), 32'(m_lrm));
      chk(req, "lr_wdata", lr_wdata, m_lrd);
    end
  endtask

  task automatic idle();
    {req_und, req_svc, req_pabt, req_dabt, irq_req, fiq_req} = '0;
    sr_wr_en = 0; rte_en = 0; rst = 0;
  endtask

  initial begin
    #(20 * 150000);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    // R1 reset state
    rst = 1; cyc("R1"); cyc("R1");
    chk("R1", "reset status", status, 32'h0000_00D3);
    idle(); cyc("R13");

    // R3 R4 R5 supervisor call
    req_svc = 1; next_pc = 32'h0000_0100; cyc("R5");
    chk("R4", "svc vector", pc_out, 32'h08);
    chk("R3", "svc mode", 32'(status[4:0]), 32'h13);
    idle(); cyc("R13");

    // R10 privileged write: clear masks, set compact state and flags
    sr_wr_en = 1; sr_wr_data = 32'hA000_0033; cyc("R10");
    idle();
    // R7 R6 undefined entry clears T, keeps F clear
    req_und = 1; next_pc = 32'h0000_0204; cyc("R7");
    chk("R7", "T bit", 32'(status[5]), 0);
    chk("R6", "F kept", 32'(status[6]), 0);
    chk("R2", "saved copy", spsr_wdata, 32'hA000_0033);
    idle();
    // R11 return restores
    rte_en = 1; rte_addr = 32'h0000_0204; cyc("R11");
    chk("R11", "restored", status, 32'hA000_0033);
    idle();

    // R8 all at once -> data abort
    {req_und, req_svc, req_pabt, req_dabt, irq_req, fiq_req} = '1;
    cyc("R8");
    chk("R8", "dabt vector", pc_out, 32'h10);
    idle(); rte_en = 1; cyc("R11"); idle();
    // R8 without dabt -> FIQ
    {req_und, req_svc, req_pabt, irq_req, fiq_req} = '1;
    cyc("R8");
    chk("R8", "fiq vector", pc_out, 32'h1C);
    chk("R6", "F set on FIQ", 32'(status[6]), 1);
    // R9 both masked, held requests are not taken
    req_und = 0; req_svc = 0; req_pabt = 0;
    cyc("R9"); cyc("R9");
    chk("R9", "no entry while masked", 32'(pc_we), 0);
    // R9 unmask F only via privileged write, FIQ then taken
    irq_req = 0;
    sr_wr_en = 1; sr_wr_data = 32'h0000_0091; cyc("R9");
    sr_wr_en = 0; cyc("R9");
    chk("R9", "fiq after unmask", pc_out, 32'h1C);
    idle(); cyc("R13");

    // R10 go to user mode, then try to change control byte
    sr_wr_en = 1; sr_wr_data = 32'h0000_0010; cyc("R10");
    sr_wr_data = 32'hF000_00D3; cyc("R10");
    chk("R10", "user ctrl locked", status, 32'hF000_0010);
    idle();
    // R11 return in user mode keeps status, loads pc
    rte_en = 1; rte_addr = 32'h0000_4444; cyc("R11");
    chk("R11", "user return pc", pc_out, 32'h0000_4444);
    idle();
    // R3 IRQ from user
    irq_req = 1; next_pc = 32'h0000_0800; cyc("R3");
    chk("R3", "irq mode", 32'(status[4:0]), 32'h12);
    cyc("R9");
    idle();

    // R12 exception beats write and return
    sr_wr_en = 1; sr_wr_data = 32'h5000_0010; req_pabt = 1; cyc("R12");
    chk("R12", "pabt vector", pc_out, 32'h0C);
    chk("R12", "write dropped", 32'(status[31:28]), 32'hF);
    idle();
    rte_en = 1; req_und = 1; cyc("R12");
    chk("R12", "und mode", 32'(status[4:0]), 32'h1B);
    idle(); cyc("R13");

    // random phase compared against the model every cycle
    for (int i = 0; i < 3000; i++) begin
      rst      = ($urandom % 97) == 0;
      req_und  = ($urandom % 11) == 0;
      req_svc  = ($urandom % 11) == 0;
      req_pabt = ($urandom % 13) == 0;
      req_dabt = ($urandom % 17) == 0;
      irq_req  = ($urandom % 4) == 0;
      fiq_req  = ($urandom % 6) == 0;
      sr_wr_en = ($urandom % 3) == 0;
      sr_wr_data = $urandom;
      rte_en   = ($urandom % 5) == 0;
      rte_addr = $urandom;
      next_pc  = $urandom;
      cyc("R12");
    end
    idle(); cyc("R13");

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule